// File: doc/BRIEF.md
# Fast PWM timer output unit

This unit pairs an 8-bit up-counter with a single compare channel to produce one pulse-width-modulated output bit. A fixed-ratio prescaler derives a one-cycle timer-clock enable from the system clock. On every enabled cycle the counter steps from zero towards its all-ones maximum, then wraps back to zero. One full period is therefore 256 timer clocks.

A 2-bit output mode sets what the compare channel does to the output. It can leave the output alone, toggle it on a match, or produce a non-inverted or an inverted PWM waveform. The compare value seen at the input is a shadow copy. It moves into the active compare register only on the timer clock where the counter wraps, so a period already under way is never disturbed.

Two sticky flags record counter wrap-around and compare matches. Each is cleared by its own write-one-to-clear input.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted, the output bit and both flags are 0. The counter, the active compare register and the prescaler count all start at 0.
- R2: The clock select `clk_sel` picks the divide ratio N. The codes 0 to 6 give 1, 8, 32, 64, 128, 256 and 1024, and code 7 also gives 1024. A free-running 10-bit count advances each cycle while `run` is high. A timer clock occurs on the cycles where the low log2(N) bits of that count are all ones (every cycle for N=1).
- R3: On each timer clock the counter increments, and from 255 it returns to 0. While `run` is low, no timer clock occurs and the counter and prescaler count hold their values.
- R4: `ovf_flag` is set on the timer clock where the counter is at 255. `ovf_clr` clears it one cycle later, and a set in the same cycle takes priority over the clear.
- R5: `cmp_flag` is set on the timer clock where the counter equals the active compare value. `cmp_clr` clears it, and a set in the same cycle takes priority.
- R6: In mode 2 (non-inverted), the output goes to 1 on the wrap timer clock and goes to 0 on a compare-match timer clock. When both happen on the same timer clock, the wrap wins. In the steady state the output is high for C+1 of every 256 timer clocks, where C is the compare value.
- R7: In mode 3 (inverted), the output goes to 0 on the wrap timer clock and goes to 1 on a match. The wrap wins when both coincide, so the output is high for 255-C of every 256 timer clocks.
- R8: In mode 1, the output inverts on each compare match and ignores the wrap. This gives a 50% duty waveform with a period of 512 timer clocks.
- R9: In mode 0, the output keeps its current value regardless of counter or compare activity.
- R10: A new `cmp_value` takes effect only on the timer clock where the counter wraps from 255 to 0. Until then, matches use the previous active value.
- R11: A compare value of 0 in mode 2 gives a one-timer-clock high pulse every 256 timer clocks. A compare value of 255 gives a constant high in mode 2 and a constant low in mode 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer enable; low freezes counter and prescaler |
| clk_sel | input | 3 | Prescaler divide-ratio select |
| cmp_value | input | 8 | Shadow compare value, loaded at wrap |
| out_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| cmp_clr | input | 1 | Write-one-to-clear for the compare flag |
| wave_out | output | 1 | Waveform output bit |
| ovf_flag | output | 1 | Sticky wrap-around flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The assertions check the following on every cycle:
- no timer clock occurs while the unit is stopped;
- the counter holds between timer clocks and returns to zero after 255;
- the active compare register changes only at a wrap;
- both flags rise after their events;
- the output's wrap edge is correct in each PWM polarity, and the output is frozen in the disconnected mode.

Other behaviours depend on several periods in sequence, and only the bench scenarios can show them:
- the duty ratios across compare values, including the one-clock spike and the steady levels at the extremes;
- the toggle period;
- the timing of each prescale ratio;
- a compare value written in mid-period being deferred to the next wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  // number of low prescaler bits that must be all ones for a timer clock
  function automatic int sel_shift(input int sel);
    case (sel)
      0:       sel_shift = 0;
      1:       sel_shift = 3;
      2:       sel_shift = 5;
      3:       sel_shift = 6;
      4:       sel_shift = 7;
      5:       sel_shift = 8;
      default: sel_shift = 10;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0]   div_q;
  logic [DIV_W-1:0]   div_d;
  logic [NUM_SEL-1:0] hit;

  // one terminal-count detector per selectable ratio
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_hit
    localparam int SH = (sel_shift(g) > DIV_W) ? DIV_W : sel_shift(g);
    if (SH == 0) begin : g_every
      assign hit[g] = 1'b1;
    end else begin : g_mask
      assign hit[g] = &div_q[SH-1:0];
    end
  end

  always_comb begin
    div_d = div_q;
    if (run) begin
      div_d = div_q + DIV_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick = run & hit[sel];

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         at_max
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d;

  assign at_max = (cnt == CNT_MAX);

  always_comb begin
    cnt_d = cnt;
    if (tick) begin
      cnt_d = at_max ? '0 : cnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         at_max,
  input  logic [W-1:0] cmp_in,
  input  logic [1:0]   mode,
  output logic [W-1:0] ocr,
  output logic         match,
  output logic         wave
);

  out_mode_e    mode_e;
  logic         wrap;
  logic [W-1:0] ocr_d;
  logic         wave_d;

  assign mode_e = out_mode_e'(mode);
  assign wrap   = tick & at_max;
  assign match  = tick & (cnt == ocr);

  // shadow value moves into the active register only at wrap
  always_comb begin
    ocr_d = ocr;
    if (wrap) begin
      ocr_d = cmp_in;
    end
  end

  // wrap event has priority over compare match in both PWM polarities
  always_comb begin
    wave_d = wave;
    unique case (mode_e)
      OM_OFF:    wave_d = wave;
      OM_TOGGLE: if (match) wave_d = ~wave;
      OM_NONINV: begin
        if (wrap)       wave_d = 1'b1;
        else if (match) wave_d = 1'b0;
      end
      OM_INV: begin
        if (wrap)       wave_d = 1'b0;
        else if (match) wave_d = 1'b1;
      end
      default:   wave_d = wave;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr  <= '0;
      wave <= 1'b0;
    end else begin
      ocr  <= ocr_d;
      wave <= wave_d;
    end
  end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic [1:0]       out_mode,
  input  logic             ovf_clr,
  input  logic             cmp_clr,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             at_max;
  logic [CNT_W-1:0] ocr;
  logic             match;
  logic             wrap;
  logic             ovf_d;
  logic             cmp_d;

  pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (clk_sel),
    .tick  (tick)
  );

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnt    (cnt),
    .at_max (at_max)
  );

  pwm_compare #(.W(CNT_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnt    (cnt),
    .at_max (at_max),
    .cmp_in (cmp_value),
    .mode   (out_mode),
    .ocr    (ocr),
    .match  (match),
    .wave   (wave_out)
  );

  assign wrap = tick & at_max;

  // sticky flags, set wins over a same-cycle clear
  always_comb begin
    ovf_d = wrap  | (ovf_flag & ~ovf_clr);
    cmp_d = match | (cmp_flag & ~cmp_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_d;
      cmp_flag <= cmp_d;
    end
  end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ocr,
  input logic [1:0]   out_mode,
  input logic         wave_out,
  input logic         ovf_flag,
  input logic         cmp_flag
);

  localparam logic [W-1:0] CNT_MAX = '1;

  // R3
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R3
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == CNT_MAX) |=> (cnt == '0));

  // R10
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == CNT_MAX) |=> $stable(ocr));

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == CNT_MAX) |=> ovf_flag);

  // R5
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == ocr) |=> cmp_flag);

  // R6
  noninv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd2 && tick && cnt == CNT_MAX) |=> wave_out);

  // R7
  inv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd3 && tick && cnt == CNT_MAX) |=> !wave_out);

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd0) |=> $stable(wave_out));

endmodule

bind pwm_timer pwm_timer_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .tick     (tick),
  .cnt      (cnt),
  .ocr      (ocr),
  .out_mode (out_mode),
  .wave_out (wave_out),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [7:0] cmp_value = 8'd0;
  logic [1:0] out_mode = 2'd0;
  logic       ovf_clr = 1'b0;
  logic       cmp_clr = 1'b0;
  logic       wave_out, ovf_flag, cmp_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_presc = 0, m_cnt = 0, m_ocr = 0;
  bit m_wave = 0, m_ovf = 0, m_cmpf = 0;

  always #5 clk = ~clk;

  pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel),
    .cmp_value(cmp_value), .out_mode(out_mode), .ovf_clr(ovf_clr),
    .cmp_clr(cmp_clr), .wave_out(wave_out), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag)
  );

  function automatic int ratio(input int s);
    case (s)
      0: return 1;   1: return 8;   2: return 32;  3: return 64;
      4: return 128; 5: return 256; default: return 1024;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_presc = 0; m_cnt = 0; m_ocr = 0; m_wave = 0; m_ovf = 0; m_cmpf = 0;
    end else begin
      bit t, wr, mt;
      t  = run && ((m_presc % ratio(clk_sel)) == ratio(clk_sel) - 1);
      wr = t && (m_cnt == 255);
      mt = t && (m_cnt == m_ocr);
      if (run) m_presc = (m_presc + 1) % 1024;
      m_ovf  = wr | (m_ovf  & !ovf_clr);
      m_cmpf = mt | (m_cmpf & !cmp_clr);
      case (out_mode)
        2'd1: if (mt) m_wave = !m_wave;
        2'd2: if (wr) m_wave = 1; else if (mt) m_wave = 0;
        2'd3: if (wr) m_wave = 0; else if (mt) m_wave = 1;
        default: ;
      endcase
      if (t) begin
        if (wr) begin m_ocr = cmp_value; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(wave_out === m_wave, cur_req, "wave_out", wave_out, m_wave);
      check(ovf_flag === m_ovf,  cur_req, "ovf_flag", ovf_flag, m_ovf);
      check(cmp_flag === m_cmpf, cur_req, "cmp_flag", cmp_flag, m_cmpf);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic high_count(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wave_out) h++;
    end
  endtask

  initial begin
    int h;
    bit held;
    wait_n(3);
    // R1 reset state
    check(wave_out === 1'b0, "R1", "wave_out in reset", wave_out, 0);
    check(ovf_flag === 1'b0, "R1", "ovf_flag in reset", ovf_flag, 0);
    check(cmp_flag === 1'b0, "R1", "cmp_flag in reset", cmp_flag, 0);
    rst_n = 1'b1;

    // R6 non-inverted duty
    cur_req = "R6"; out_mode = 2'd2; cmp_value = 8'd64; run = 1'b1;
    wait_n(600); high_count(256, h);
    check(h == 65, "R6", "high clocks", h, 65);

    // R7 inverted duty
    cur_req = "R7"; out_mode = 2'd3;
    wait_n(600); high_count(256, h);
    check(h == 191, "R7", "high clocks", h, 191);

    // R11 extremes
    cur_req = "R11"; out_mode = 2'd2; cmp_value = 8'd0;
    wait_n(600); high_count(256, h);
    check(h == 1, "R11", "spike high clocks", h, 1);
    cmp_value = 8'd255;
    wait_n(600); high_count(512, h);
    check(h == 512, "R11", "constant high", h, 512);
    out_mode = 2'd3;
    wait_n(600); high_count(512, h);
    check(h == 0, "R11", "constant low", h, 0);

    // R8 toggle
    cur_req = "R8"; out_mode = 2'd1; cmp_value = 8'd10;
    wait_n(600); high_count(512, h);
    check(h == 256, "R8", "toggle high clocks", h, 256);

    // R9 disconnected mode holds the output
    cur_req = "R9"; out_mode = 2'd0; @(negedge clk); held = wave_out;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      check(wave_out === held, "R9", "held wave", wave_out, held);
    end

    // R10 shadow compare deferred until wrap
    cur_req = "R10"; out_mode = 2'd2; cmp_value = 8'd200;
    wait_n(600);
    while (wave_out !== 1'b1) @(negedge clk);
    while (wave_out !== 1'b0) @(negedge clk);
    cmp_value = 8'd20;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      check(wave_out === 1'b0, "R10", "old compare still active", wave_out, 0);
    end
    wait_n(600); high_count(256, h);
    check(h == 21, "R10", "new compare high clocks", h, 21);

    // R4 R5 clears and stickiness
    cur_req = "R4"; run = 1'b0; ovf_clr = 1'b1; cmp_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0; cmp_clr = 1'b0;
    check(ovf_flag === 1'b0, "R4", "ovf cleared", ovf_flag, 0);
    check(cmp_flag === 1'b0, "R5", "cmp cleared", cmp_flag, 0);
    // R3 stopped timer holds
    cur_req = "R3"; held = wave_out;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      check(wave_out === held && ovf_flag === 1'b0, "R3", "stopped hold", wave_out, held);
    end
    cur_req = "R5"; run = 1'b1;
    wait_n(300);
    check(ovf_flag === 1'b1, "R4", "ovf set after wrap", ovf_flag, 1);
    check(cmp_flag === 1'b1, "R5", "cmp set after match", cmp_flag, 1);
    // R4 clear during a run, model checks set-wins cycles
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin
      ovf_clr = 1'b1; cmp_clr = 1'b1; @(negedge clk);
      ovf_clr = 1'b0; cmp_clr = 1'b0; wait_n(97);
    end

    // R2 prescaler ratios
    cur_req = "R2"; clk_sel = 3'd1; out_mode = 2'd2; cmp_value = 8'd64;
    wait_n(4800); high_count(2048, h);
    check(h == 520, "R2", "divide-by-8 high clocks", h, 520);
    for (int s = 2; s < 8; s++) begin
      clk_sel = s[2:0];
      wait_n(3000);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule